// File: doc/BRIEF.md
# Variable-Length DMA Channel Engine

This block is one DMA channel. A start pulse latches a source address, a destination address, a 3-bit length mode, a 13-bit maximum count and a unit-size select. After that, each trigger pulse moves one unit from the source to the destination over a simple 16-bit-address memory port. A unit is a byte or a 16-bit word. Both addresses advance by the unit size after every unit.

The number of units comes from one of two places. In the fixed modes it is the maximum-count field itself. In the variable modes it is read from the first unit moved (the length unit). A per-mode offset is added to that value, and the result is capped by the maximum-count field. The channel raises `busy` while it works and gives a one-cycle `done` pulse when it finishes. A reserved length-mode code sets `err` and makes no memory access.

The control is a five-state machine:
- **ST_IDLE**
  - goes to ST_WAIT on an accepted start;
  - goes to ST_DONE on a start in a fixed mode with a zero count;
  - stays in ST_IDLE on a start with a reserved mode, and sets `err`.
- **ST_WAIT** goes to ST_READ on a trigger.
- **ST_READ** goes to ST_WRITE unconditionally.
- **ST_WRITE** goes to ST_DONE when no units remain, and back to ST_WAIT otherwise.
- **ST_DONE** goes to ST_IDLE unconditionally.

Top module: `vlen_dma_chan`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_rd` and `mem_wr` are all low. Neither memory strobe is ever high while `busy` is low.
- R2: Length modes 3'b000 and 3'b111 move exactly `cfg_maxcnt` units, one unit for each trigger pulse taken in ST_WAIT.
- R3: With `cfg_wide`=0, units are bytes. Both addresses step by 1, and `mem_wdata[15:8]` is zero. With `cfg_wide`=1, units are 16-bit words and both addresses step by 2.
- R4: Length mode 3'b001 moves the length unit plus min(L+1, `cfg_maxcnt`) further units. L is the length value read from the first unit.
- R5: Length mode 3'b010 moves min(L, `cfg_maxcnt`) units in total, counting the length unit. When that value is 0, only the length unit is moved.
- R6: Length modes 3'b011 and 3'b100 move the length unit plus min(L+2, max) and min(L+3, max) further units respectively, where max is `cfg_maxcnt`.
- R7: In every variable mode, the count taken from the data never exceeds `cfg_maxcnt`.
- R8: L is `mem_rdata[7:0]` in byte mode and `mem_rdata[12:0]` in word mode. Bits 15:13 of a length word are ignored.
- R9: Length modes 3'b101 and 3'b110 set `err` and start no transfer: no memory strobe, no `busy`, no `done`. `err` stays set until the next start is accepted, and that start clears it.
- R10: A transfer ends with `done` high for exactly one cycle, with `busy` still high. `busy` is low on the following cycle.
- R11: Each unit is a `mem_rd` cycle followed directly by a `mem_wr` cycle. The write data is the read data returned in the write cycle. A trigger outside ST_WAIT has no effect.
- R12: A fixed mode with `cfg_maxcnt`=0 gives `done` without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch the configuration and arm the channel (taken only in ST_IDLE) |
| trig | input | 1 | Move one unit (taken only in ST_WAIT) |
| cfg_src | input | 16 | Source start address |
| cfg_dst | input | 16 | Destination start address |
| cfg_lmode | input | 3 | Length-mode code |
| cfg_maxcnt | input | 13 | Fixed count, or cap on the count taken from the data |
| cfg_wide | input | 1 | 0 = byte units, 1 = 16-bit word units |
| mem_rd | output | 1 | Read strobe |
| mem_raddr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid in the cycle after `mem_rd` |
| mem_wr | output | 1 | Write strobe |
| mem_waddr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Reserved length mode was requested |

## Verification
The assertions check the following on every cycle:
- `done` lasts one cycle and is followed by idle;
- every read is followed directly by a write, and every write follows a read;
- the strobes stay low outside `busy`, and also while `err` is set;
- consecutive read addresses and consecutive write addresses within a transfer step by the unit size.

Whether the channel moved the right number of units cannot be seen cycle by cycle. Only the bench scenarios show it: each length mode, the cap, the 13-bit word length value, the zero-length cases and the error path, with every write compared against an independently computed expectation.

// File: rtl/vlen_dma_pkg.sv
package vlen_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } dma_state_e;

    localparam logic [2:0] LM_FIXED     = 3'b000;
    localparam logic [2:0] LM_PLUS1     = 3'b001;
    localparam logic [2:0] LM_INCL      = 3'b010;
    localparam logic [2:0] LM_PLUS2     = 3'b011;
    localparam logic [2:0] LM_PLUS3     = 3'b100;
    localparam logic [2:0] LM_RSVD_A    = 3'b101;
    localparam logic [2:0] LM_RSVD_B    = 3'b110;
    localparam logic [2:0] LM_FIXED_ALT = 3'b111;

    function automatic logic lmode_reserved(input logic [2:0] m);
        return (m == LM_RSVD_A) || (m == LM_RSVD_B);
    endfunction

    function automatic logic lmode_fixed(input logic [2:0] m);
        return (m == LM_FIXED) || (m == LM_FIXED_ALT);
    endfunction

    function automatic logic lmode_incl(input logic [2:0] m);
        return m == LM_INCL;
    endfunction

    function automatic logic [1:0] lmode_offset(input logic [2:0] m);
        logic [1:0] off;
        unique case (m)
            LM_PLUS1: off = 2'd1;
            LM_PLUS2: off = 2'd2;
            LM_PLUS3: off = 2'd3;
            default:  off = 2'd0;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/vlen_len_calc.sv
module vlen_len_calc
    import vlen_dma_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 13
) (
    input  logic [2:0]    mode,
    input  logic          wide,
    input  logic [DW-1:0] first_data,
    input  logic [CW-1:0] maxcnt,
    output logic [CW-1:0] after_len
);
    localparam int SW = CW + 1;

    logic [CW-1:0] raw_len;
    logic [SW-1:0] sum_len;
    logic [CW-1:0] capped;
    logic          unused_hi;

    assign unused_hi = ^first_data[DW-1:CW];

    always_comb begin
        raw_len = wide ? first_data[CW-1:0] : CW'(first_data[7:0]);
        sum_len = {1'b0, raw_len} + SW'(lmode_offset(mode));
        capped  = (sum_len > {1'b0, maxcnt}) ? maxcnt : sum_len[CW-1:0];
        if (lmode_incl(mode)) begin
            after_len = (capped == '0) ? '0 : capped - 1'b1;
        end else begin
            after_len = capped;
        end
    end

endmodule

// File: rtl/vlen_addr_gen.sv
module vlen_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic          advance,
    input  logic          wide,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q
);
    logic [AW-1:0] step;

    assign step = wide ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            src_q <= src_in;
            dst_q <= dst_in;
        end else if (advance) begin
            src_q <= src_q + step;
            dst_q <= dst_q + step;
        end
    end

endmodule

// File: rtl/vlen_dma_chan.sv
module vlen_dma_chan
    import vlen_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          trig,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [2:0]    cfg_lmode,
    input  logic [CW-1:0] cfg_maxcnt,
    input  logic          cfg_wide,
    output logic          mem_rd,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam int HB = DW - 8;

    dma_state_e    state_q, state_d;
    logic [2:0]    mode_q;
    logic          wide_q;
    logic [CW-1:0] max_q;
    logic [CW-1:0] rem_q;
    logic          first_q;
    logic          err_q;

    logic          accept;
    logic          start_ok;
    logic          zero_fixed;
    logic [CW-1:0] after_len;
    logic [CW-1:0] rem_after;
    logic          last_unit;

    assign accept     = (state_q == ST_IDLE) && start;
    assign start_ok   = accept && !lmode_reserved(cfg_lmode);
    assign zero_fixed = lmode_fixed(cfg_lmode) && (cfg_maxcnt == '0);
    assign rem_after  = first_q ? after_len : rem_q - 1'b1;
    assign last_unit  = (rem_after == '0);

    vlen_len_calc #(.DW(DW), .CW(CW)) i_len_calc (
        .mode       (mode_q),
        .wide       (wide_q),
        .first_data (mem_rdata),
        .maxcnt     (max_q),
        .after_len  (after_len)
    );

    vlen_addr_gen #(.AW(AW)) i_addr_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_ok),
        .src_in  (cfg_src),
        .dst_in  (cfg_dst),
        .advance (state_q == ST_WRITE),
        .wide    (wide_q),
        .src_q   (mem_raddr),
        .dst_q   (mem_waddr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = zero_fixed ? ST_DONE : ST_WAIT;
            end
            ST_WAIT:  if (trig) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = last_unit ? ST_DONE : ST_WAIT;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Channel context and unit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= LM_FIXED;
            wide_q  <= 1'b0;
            max_q   <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (accept) err_q <= lmode_reserved(cfg_lmode);
            if (start_ok) begin
                mode_q  <= cfg_lmode;
                wide_q  <= cfg_wide;
                max_q   <= cfg_maxcnt;
                rem_q   <= cfg_maxcnt;
                first_q <= !lmode_fixed(cfg_lmode);
            end else if (state_q == ST_WRITE) begin
                first_q <= 1'b0;
                rem_q   <= rem_after;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = (state_q == ST_READ);
        mem_wr    = (state_q == ST_WRITE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        err       = err_q;
        mem_wdata = wide_q ? mem_rdata : {{HB{1'b0}}, mem_rdata[7:0]};
    end

endmodule

// File: rtl/vlen_dma_chk.sv
module vlen_dma_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          wide,
    input logic [AW-1:0] mem_raddr,
    input logic [AW-1:0] mem_waddr
);
    logic [AW-1:0] prev_wa, prev_ra;
    logic          have_w, have_r;
    logic [AW-1:0] step;

    assign step = wide ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_wa <= '0;
            prev_ra <= '0;
            have_w  <= 1'b0;
            have_r  <= 1'b0;
        end else if (!busy) begin
            have_w <= 1'b0;
            have_r <= 1'b0;
        end else begin
            if (mem_wr) begin
                have_w  <= 1'b1;
                prev_wa <= mem_waddr;
            end
            if (mem_rd) begin
                have_r  <= 1'b1;
                prev_ra <= mem_raddr;
            end
        end
    end

    // R1
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    // R3
    waddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && have_w) |-> (mem_waddr == prev_wa + step));

    // R3
    raddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && have_r) |-> (mem_raddr == prev_ra + step));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_rd && !mem_wr && !done));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !busy);

    // R11
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R11
    wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

endmodule

bind vlen_dma_chan vlen_dma_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .wide      (wide_q),
    .mem_raddr (mem_raddr),
    .mem_waddr (mem_waddr)
);

// File: tb/test_vlen_dma_chan.sv
`timescale 1ns/1ps
module test_vlen_dma_chan;

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] cfg_src = '0;
    logic [15:0] cfg_dst = '0;
    logic [2:0]  cfg_lmode = '0;
    logic [12:0] cfg_maxcnt = '0;
    logic        cfg_wide = 1'b0;
    logic        mem_rd, mem_wr, busy, done, err;
    logic [15:0] mem_raddr, mem_waddr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [7:0]  mem [0:1023];
    item_t       exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          done_cnt = 0;
    int          rd_cnt = 0;
    string       cur_req = "R2";

    always #10 clk = ~clk;

    vlen_dma_chan i_vlen_dma_chan (
        .clk(clk), .rst_n(rst_n), .start(start), .trig(trig),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_lmode(cfg_lmode),
        .cfg_maxcnt(cfg_maxcnt), .cfg_wide(cfg_wide),
        .mem_rd(mem_rd), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: registered read, byte-lane write
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= {mem[10'(mem_raddr + 16'd1)], mem[10'(mem_raddr)]};
        if (mem_wr) begin
            mem[10'(mem_waddr)] <= mem_wdata[7:0];
            if (cfg_wide) mem[10'(mem_waddr + 16'd1)] <= mem_wdata[15:8];
        end
    end

    // monitor: pops expected writes and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (done) begin
                done_cnt++;
                chk(busy == 1'b1, "R10", "busy during done", int'(busy), 1);
            end
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected write", int'(mem_waddr), 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(mem_waddr == it.a, cur_req, "write address", int'(mem_waddr), int'(it.a));
                    chk(mem_wdata == it.d, cur_req, "write data", int'(mem_wdata), int'(it.d));
                end
            end
        end
    end

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // expected total unit count, from the requirements
    function automatic int exp_units(input logic [2:0] m, input int l, input int mx);
        case (m)
            3'b000, 3'b111: return mx;
            3'b001: return 1 + min2(l + 1, mx);
            3'b010: return (min2(l, mx) == 0) ? 1 : min2(l, mx);
            3'b011: return 1 + min2(l + 2, mx);
            3'b100: return 1 + min2(l + 3, mx);
            default: return 0;
        endcase
    endfunction

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [15:0] src, input logic [15:0] dst,
                            input logic [2:0] m, input int mx, input logic wide);
        int l, units, step, rd0;
        step = wide ? 2 : 1;
        l = wide ? int'({mem[10'(src + 16'd1)], mem[10'(src)]} & 16'h1fff) : int'(mem[10'(src)]);
        units = exp_units(m, l, mx);
        for (int i = 0; i < units; i++) begin
            item_t it;
            logic [15:0] sa;
            sa = src + 16'(i * step);
            it.a = dst + 16'(i * step);
            it.d = wide ? {mem[10'(sa + 16'd1)], mem[10'(sa)]} : {8'h00, mem[10'(sa)]};
            exp_q.push_back(it);
        end
        cur_req = req;
        @(negedge clk);
        cfg_src = src; cfg_dst = dst; cfg_lmode = m;
        cfg_maxcnt = 13'(mx); cfg_wide = wide;
        done_cnt = 0;
        rd0 = rd_cnt;
        pulse_start();
        for (int i = 0; i < units + 2 && done_cnt == 0; i++) pulse_trig();
        chk(done_cnt == 1, req, "done pulse count", done_cnt, 1);
        chk(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
        // triggers while idle must do nothing (R11)
        pulse_trig();
        pulse_trig();
        chk(rd_cnt - rd0 == units, "R11", "reads incl. idle triggers", rd_cnt - rd0, units);
        chk(done_cnt == 1, "R10", "single done", done_cnt, 1);
        chk(busy == 1'b0, "R10", "idle after done", int'(busy), 0);
        chk(err == 1'b0, "R9", "err clear on valid start", int'(err), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rd0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        mem[10'h040] = 8'd2;                       // mode 001 length
        mem[10'h060] = 8'd5;                       // mode 010 length
        mem[10'h080] = 8'd1;  mem[10'h081] = 8'h00; // mode 011 word length
        mem[10'h0A0] = 8'd2;                       // mode 100 length (capped)
        mem[10'h0C0] = 8'd0;                       // mode 010 zero length
        mem[10'h0E0] = 8'h02; mem[10'h0E1] = 8'hE0; // word length, bits 15:13 set
        mem[10'h100] = 8'd200;                     // mode 001 capped
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && err == 0, "R1", "reset outputs",
            int'({busy, done, err}), 0);
        chk(mem_rd == 0 && mem_wr == 0, "R1", "reset strobes", int'({mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0, "R1", "idle after reset", int'(busy), 0);

        run_case("R2", 16'h0010, 16'h0200, 3'b000, 4, 1'b0);
        run_case("R3", 16'h0020, 16'h0220, 3'b111, 3, 1'b1);
        run_case("R4", 16'h0040, 16'h0240, 3'b001, 10, 1'b0);
        run_case("R5", 16'h0060, 16'h0260, 3'b010, 10, 1'b0);
        run_case("R6", 16'h0080, 16'h0280, 3'b011, 10, 1'b1);
        run_case("R7", 16'h00A0, 16'h02A0, 3'b100, 3, 1'b0);
        run_case("R5", 16'h00C0, 16'h02C0, 3'b010, 10, 1'b0);
        run_case("R8", 16'h00E0, 16'h02E0, 3'b010, 20, 1'b1);
        run_case("R12", 16'h0120, 16'h0300, 3'b000, 0, 1'b0);
        run_case("R7", 16'h0100, 16'h0320, 3'b001, 5, 1'b0);

        // R9: reserved mode
        cur_req = "R9";
        done_cnt = 0;
        rd0 = rd_cnt;
        @(negedge clk);
        cfg_lmode = 3'b101; cfg_maxcnt = 13'd4;
        pulse_start();
        chk(err == 1'b1, "R9", "err set on reserved mode", int'(err), 1);
        chk(busy == 1'b0, "R9", "not busy on reserved mode", int'(busy), 0);
        pulse_trig();
        pulse_trig();
        chk(rd_cnt == rd0 && done_cnt == 0, "R9", "no access or done",
            rd_cnt - rd0 + done_cnt, 0);
        chk(err == 1'b1, "R9", "err held", int'(err), 1);
        @(negedge clk);
        cfg_lmode = 3'b110;
        pulse_start();
        chk(err == 1'b1 && busy == 1'b0, "R9", "second reserved code",
            int'({err, busy}), 2);
        run_case("R2", 16'h0140, 16'h0340, 3'b111, 2, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule